// File: doc/BRIEF.md
# Multi-Hart Core-Local Timer and Software Interruptor

This block serves a build-time number of harts from a single register space. One 64-bit time counter advances by one on every clock cycle and is shared by all harts. Each hart owns a 64-bit compare value and one software-interrupt pending bit. It also owns two interrupt lines: a timer line and a software line.

Software reaches every register through a simple 32-bit word bus. A write is one cycle with `bus_we` high, and read data is returned combinationally for the current address. The timer line of a hart stays high for as long as the counter is at or beyond that hart's compare value. Software lowers the line by writing a larger compare value.

The map places the software bits at the bottom of the space. The compare registers follow from 0x4000, and the counter sits at 0xBFF8, so a hart's interrupt code finds them where it expects.

Top module: `clint_core`

## Requirements
- R1: After reset the time counter reads zero, every software bit reads zero, every compare register reads 0xFFFFFFFF in both halves, and all interrupt outputs are low.
- R2: With no write to the time counter, the counter is exactly one larger on each clock cycle than on the one before.
- R3: A write to byte address 0xBFF8 or 0xBFFC replaces the low or high 32 bits of the time counter on the next cycle. The other half keeps its value, and the increment is skipped for that cycle.
- R4: Hart h's compare register reads and writes at 0x4000+8h (bits 31:0) and 0x4000+8h+4 (bits 63:32). A write takes effect on the next cycle.
- R5: `tmr_irq[h]` is high exactly when the counter is greater than or equal to hart h's compare value, compared as unsigned 64-bit numbers.
- R6: A raised `tmr_irq[h]` stays high until a bus write occurs; writing a compare value above the counter lowers it on the next cycle.
- R7: Address 4h holds hart h's software bit. Only write-data bit 0 is stored, bits 31:1 read as zero, and `sw_irq[h]` equals the stored bit.
- R8: A write to one hart's register changes no other hart's registers or outputs.
- R9: Reads from addresses that map no register return zero, and writes to them change nothing. Address bits 1:0 are ignored.
- R10: Byte address 0xBFF8 reads bits 31:0 of the time counter and 0xBFFC reads bits 63:32, reflecting the value of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tmr_irq | output | NHARTS | Per-hart timer interrupt |
| sw_irq | output | NHARTS | Per-hart software interrupt |

## Verification
Read data is due in the same cycle as the address, and a written register shows its new value after the clock edge that captures the write. The interrupt outputs follow the registers with no further delay. The bench therefore drives every input at the falling edge and samples one nanosecond later. Its reference model advances on the rising edge from the same driven inputs, so the counter value it expects already includes every increment since reset. The exact cycle at which the counter reaches a compare value is then checked one cycle at a time.

// File: rtl/clint_core.sv
module clint_core #(
  parameter int NHARTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [15:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NHARTS-1:0] tmr_irq,
  output logic [NHARTS-1:0] sw_irq
);
  localparam logic [15:0] CMP_BASE = 16'h4000;
  localparam logic [15:0] TIME_LO  = 16'hBFF8;
  localparam logic [15:0] TIME_HI  = 16'hBFFC;

  logic [63:0]       mtime;
  logic [63:0]       cmp [NHARTS];
  logic [NHARTS-1:0] msip;

  wire [15:0] wa = {bus_addr[15:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n)                    mtime <= '0;
    else if (bus_we && wa == TIME_LO) mtime <= {mtime[63:32], bus_wdata};
    else if (bus_we && wa == TIME_HI) mtime <= {bus_wdata, mtime[31:0]};
    else                           mtime <= mtime + 64'd1;
  end

  always_ff @(posedge clk) begin
    for (int h = 0; h < NHARTS; h++) begin
      if (!rst_n) begin
        msip[h] <= 1'b0;
        cmp[h]  <= '1;
      end else if (bus_we) begin
        if (wa == 16'(4*h))             msip[h]       <= bus_wdata[0];
        if (wa == CMP_BASE + 16'(8*h))     cmp[h][31:0]  <= bus_wdata;
        if (wa == CMP_BASE + 16'(8*h + 4)) cmp[h][63:32] <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NHARTS; g++) begin : g_irq
    assign tmr_irq[g] = (mtime >= cmp[g]);
  end
  assign sw_irq = msip;

  always_comb begin
    bus_rdata = '0;
    if (wa == TIME_LO) bus_rdata = mtime[31:0];
    if (wa == TIME_HI) bus_rdata = mtime[63:32];
    for (int h = 0; h < NHARTS; h++) begin
      if (wa == 16'(4*h))             bus_rdata = {31'b0, msip[h]};
      if (wa == CMP_BASE + 16'(8*h))     bus_rdata = cmp[h][31:0];
      if (wa == CMP_BASE + 16'(8*h + 4)) bus_rdata = cmp[h][63:32];
    end
  end
endmodule

module clint_core_chk #(
  parameter int NHARTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [15:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NHARTS-1:0] tmr_irq,
  input logic [NHARTS-1:0] sw_irq,
  input logic [63:0]       mtime
);
  wire [15:0] wa = {bus_addr[15:2], 2'b00};
  wire time_wr = bus_we && (wa == 16'hBFF8 || wa == 16'hBFFC);

  assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !time_wr |=> mtime == $past(mtime) + 64'd1);

  assert_time_lo_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wa == 16'hBFF8) |=> mtime == {$past(mtime[63:32]), $past(bus_wdata)});

  assert_time_hi_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wa == 16'hBFFC) |=> mtime == {$past(bus_wdata), $past(mtime[31:0])});

  assert_tmr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> (($past(tmr_irq) & ~tmr_irq) == '0));

  assert_sw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(sw_irq));

  assert_sw_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wa < 16'h4000) |-> bus_rdata[31:1] == '0);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wa >= 16'(16'h4000 + 8*NHARTS) && wa < 16'hBFF8) |-> bus_rdata == '0);
endmodule

bind clint_core clint_core_chk #(.NHARTS(NHARTS)) u_chk (.*);

// File: tb/clint_core_test.sv
module clint_core_test;
  localparam int NH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NH-1:0] tmr_irq, sw_irq;

  int errors = 0;
  int checks = 0;

  logic [63:0]   exp_time;
  logic [63:0]   exp_cmp [NH];
  logic [NH-1:0] exp_msip;

  always #2 clk = ~clk;

  clint_core #(.NHARTS(NH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tmr_irq(tmr_irq), .sw_irq(sw_irq)
  );

  // reference model from the requirements
  always @(posedge clk) begin
    logic [15:0] a;
    a = {addr[15:2], 2'b00};
    if (!rst_n) begin
      exp_time <= '0;
      exp_msip <= '0;
      for (int h = 0; h < NH; h++) exp_cmp[h] <= '1;
    end else begin
      if (we && a == 16'hBFF8)      exp_time <= {exp_time[63:32], wdata};
      else if (we && a == 16'hBFFC) exp_time <= {wdata, exp_time[31:0]};
      else                          exp_time <= exp_time + 64'd1;
      for (int h = 0; h < NH; h++) if (we) begin
        if (a == 16'(4*h))          exp_msip[h] <= wdata[0];
        if (a == 16'(16'h4000 + 8*h))     exp_cmp[h][31:0]  <= wdata;
        if (a == 16'(16'h4000 + 8*h + 4)) exp_cmp[h][63:32] <= wdata;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [15:0] ra);
    logic [15:0] a;
    a = {ra[15:2], 2'b00};
    if (a == 16'hBFF8) return exp_time[31:0];
    if (a == 16'hBFFC) return exp_time[63:32];
    for (int h = 0; h < NH; h++) begin
      if (a == 16'(4*h)) return {31'b0, exp_msip[h]};
      if (a == 16'(16'h4000 + 8*h))     return exp_cmp[h][31:0];
      if (a == 16'(16'h4000 + 8*h + 4)) return exp_cmp[h][63:32];
    end
    return 32'h0;
  endfunction

  function automatic logic [NH-1:0] exp_tmr();
    logic [NH-1:0] r;
    for (int h = 0; h < NH; h++) r[h] = (exp_time >= exp_cmp[h]);
    return r;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input string tag);
    addr = a;
    #1;
    chk(64'(rdata), 64'(exp_rd(a)), tag);
  endtask

  task automatic irq_chk(input string tag);
    #1;
    chk(64'(tmr_irq), 64'(exp_tmr()), {tag, " tmr"});
    chk(64'(sw_irq), 64'(exp_msip), {tag, " sw"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] t0, t1;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(64'(tmr_irq), 64'h0, "R1 tmr after reset");
    chk(64'(sw_irq), 64'h0, "R1 sw after reset");
    chk(exp_time < 64'd4 ? 64'd1 : 64'd0, 64'd1, "R1 counter near zero");
    rd_chk(16'hBFF8, "R1 time lo");
    for (int h = 0; h < NH; h++) begin
      rd_chk(16'(16'h4000 + 8*h), "R1 cmp lo");
      chk(64'(rdata), 64'hFFFFFFFF, "R1 cmp lo ones");
      rd_chk(16'(16'h4000 + 8*h + 4), "R1 cmp hi");
      rd_chk(16'(4*h), "R1 msip");
    end

    // R2 step of one per cycle
    @(negedge clk); addr = 16'hBFF8; #1; t0 = rdata;
    repeat (5) @(negedge clk); #1; t1 = rdata;
    chk(64'(t1 - t0), 64'd5, "R2 five cycles");

    // R3/R10 write low half, carry into high half
    wr(16'hBFFC, 32'h0000_0007);
    rd_chk(16'hBFFC, "R3 hi write");
    wr(16'hBFF8, 32'hFFFF_FFFD);
    #1;
    chk(64'(uut.bus_rdata), 64'(exp_rd(addr)), "R3 lo readback");
    rd_chk(16'hBFF8, "R10 time lo");
    repeat (4) @(negedge clk);
    rd_chk(16'hBFFC, "R10 time hi after carry");
    chk(64'(rdata), 64'h8, "R3 carry into hi");

    // R4/R5 compare boundary on hart 1
    wr(16'h400C, exp_time[63:32]);
    @(negedge clk); we = 1'b1; addr = 16'h4008; wdata = exp_time[31:0] + 32'd6;
    @(negedge clk); we = 1'b0;
    rd_chk(16'h4008, "R4 cmp lo readback");
    rd_chk(16'h400C, "R4 cmp hi readback");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      irq_chk("R5 boundary");
    end
    chk(64'(tmr_irq[1]), 64'd1, "R5 hart1 fired");
    chk(64'(tmr_irq[0] | tmr_irq[2] | tmr_irq[3]), 64'd0, "R8 others quiet");

    // R6 clear by larger compare
    wr(16'h4008, exp_time[31:0] + 32'd1000);
    irq_chk("R6 cleared");
    chk(64'(tmr_irq[1]), 64'd0, "R6 hart1 low");

    // R7 software bit
    wr(16'h0009, 32'hFFFF_FFFF);
    rd_chk(16'h0008, "R7 msip readback");
    chk(64'(rdata), 64'h1, "R7 only bit0");
    chk(64'(sw_irq), 64'b0100, "R7 sw line");
    wr(16'h0008, 32'hFFFF_FFFE);
    chk(64'(sw_irq), 64'b0000, "R7 bit0 clear");

    // R9 unmapped
    wr(16'h8000, 32'hDEAD_BEEF);
    rd_chk(16'h8000, "R9 unmapped read");
    chk(64'(rdata), 64'h0, "R9 zero");
    wr(16'h0010, 32'h1);
    irq_chk("R9 no effect");
    rd_chk(16'h0010, "R9 msip beyond harts");

    // random mix, R8 independence checked on every output
    for (int i = 0; i < 400; i++) begin
      int h;
      logic [15:0] a;
      logic [31:0] d;
      h = int'($urandom_range(NH - 1));
      case ($urandom_range(7))
        0, 1: begin a = 16'(4*h); d = $urandom; end
        2, 3: begin a = 16'(16'h4000 + 8*h); d = exp_time[31:0] + $urandom_range(40); end
        4:    begin a = 16'(16'h4000 + 8*h + 4); d = exp_time[63:32] + 32'($urandom_range(1)); end
        5:    begin a = 16'hBFF8; d = $urandom; end
        6:    begin a = 16'h6000; d = $urandom; end
        default: begin a = 16'h4000 + 16'(8*h); d = $urandom_range(20); end
      endcase
      wr(a, d);
      irq_chk("R8 random outputs");
      rd_chk(16'($urandom_range(16'h4020)) & 16'hFFFC, "R4 random read");
      rd_chk(16'(16'h4000 + 8*h), "R8 random cmp");
      if (i % 50 == 0) rd_chk(16'hBFFC, "R10 random hi");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule